// File: doc/BRIEF.md
# Quadrature State Rotation Mixer

This block shifts the frequency of a hard-limited quadrature signal. Each clock it takes one bit per axis, so the input is always one of the four corners of the (I, Q) plane. A moving input point means the input carries a frequency offset. Counterclockwise motion is a positive offset and clockwise motion is a negative one.

The block adds a programmable offset of its own by turning every input point through a rotation state that steps around the circle. The state is a 2-bit counter driven by a reload-based prescaler. Its upper bit controls a half-turn stage and its lower bit controls a quarter-turn stage. The two stages sit in series, one register each, and a direction input picks which way the state counts.

When the block's rotation exactly cancels the input's motion, the output stands still. This static output is what a downstream phase/frequency detector needs to declare lock.

Top module: `qrot_mixer`

## Requirements
- R1: Axis bit 1 means +1 and bit 0 means -1. The output pair equals the input pair sampled two rising edges earlier, turned counterclockwise by k quarter turns, where k is the rotation state sampled on that same edge. With k = 0 the point passes unchanged.
- R2: When the upper state bit is set and the lower bit is clear (k = 2), both axis bits of the point are inverted: (I,Q) becomes (-I,-Q).
- R3: When the lower state bit is set, the quarter-turn stage maps (I,Q) to (-Q,I). For k = 1 that is the whole rotation. For k = 3, where both bits are set, the net result is (Q,-I).
- R4: With `dir_up` = 1 the rotation state increments modulo 4 at each advance. With `dir_up` = 0 it decrements.
- R5: The rotation state advances once every N rising edges, where N is `reload` and a reload of 0 acts as 1. After reset the first advance happens on the N-th edge.
- R6: Both stages use the rotation state from the edge on which the input sample was taken. The quarter-turn control is delayed by one register to match the half-turn stage.
- R7: If the input steps counterclockwise once per clock while the block counts down with N = 1, the output holds one fixed point.
- R8: While `rst_n` is low, the output pair reads (0,0), `out_vld` is low and the state returns to 0. After release, `out_vld` is still low after the first edge and high from the second edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_up | input | 1 | 1: rotation state counts up; 0: counts down |
| reload | input | RELOAD_W | Clocks per rotation step (0 treated as 1) |
| in_i | input | 1 | In-phase sign bit of the limited input |
| in_q | input | 1 | Quadrature sign bit of the limited input |
| out_i | output | 1 | In-phase sign bit after rotation |
| out_q | output | 1 | Quadrature sign bit after rotation |
| out_vld | output | 1 | Output pair carries a post-reset sample |

## Verification
A stationary input at (+1,+1) with a step on every clock is the main pattern. It exposes each of the four rotations separately, so a swapped stage, a wrong negation or a misaligned quarter-turn control shows up as one wrong corner. Running the same pattern with the direction reversed separates count-up from count-down. Slower reload values and a reload of zero test the prescaler's step period and its first-advance position. An input rotating counterclockwise against a down-counting state must give a frozen output, which checks that both stages act on the same sample. A reset in the middle of a run checks the valid delay and the state restart.

// File: rtl/qrot_pkg.sv
// qrot_pkg: shared point type, stage kind and rotation helpers for the
// quadrature rotation mixer. Assumes bit 1 = +1 and bit 0 = -1 on each axis.
package qrot_pkg;

    // One constellation corner, one sign bit per axis.
    typedef struct packed {
        logic i;
        logic q;
    } qpt_t;

    // Which fixed turn a rotation stage applies when enabled.
    typedef enum logic {
        ROT_HALF    = 1'b0,
        ROT_QUARTER = 1'b1
    } rot_kind_e;

    localparam int unsigned PHASE_W = 2;

    // Half turn: (I,Q) -> (-I,-Q); negation of a sign bit is inversion.
    function automatic qpt_t rot_half(input qpt_t p);
        qpt_t r;
        r.i = ~p.i;
        r.q = ~p.q;
        return r;
    endfunction

    // Quarter turn counterclockwise: (I,Q) -> (-Q,I).
    function automatic qpt_t rot_quarter(input qpt_t p);
        qpt_t r;
        r.i = ~p.q;
        r.q = p.i;
        return r;
    endfunction

endpackage

// File: rtl/qrot_rate_gen.sv
// qrot_rate_gen: prescaled 2-bit rotation state generator.
// The state advances once every N rising edges (N = reload, 0 acts as 1),
// up or down per dir_up. Bit 1 drives the half-turn stage, bit 0 the
// quarter-turn stage, so the half-turn control runs at half the rate.
// Assumes reload may change at any time; an oversized prescale count is
// cut short on the next edge.
module qrot_rate_gen import qrot_pkg::*; #(
    parameter int unsigned RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_up,
    input  logic [RELOAD_W-1:0] reload,
    output logic [PHASE_W-1:0]  phase_o
);

    localparam logic [RELOAD_W-1:0] ONE  = RELOAD_W'(1);
    localparam logic [RELOAD_W-1:0] ZERO = '0;

    logic [RELOAD_W-1:0] pre_cnt;
    logic [RELOAD_W-1:0] last_cnt;
    logic                step_now;
    logic [PHASE_W-1:0]  phase_q;
    logic [PHASE_W-1:0]  phase_nxt;

    // Terminal prescale count; a reload of zero behaves like one.
    always_comb last_cnt = (reload == ZERO) ? ZERO : (reload - ONE);

    // Advance on the edge where the prescaler reaches its terminal count.
    always_comb step_now = (pre_cnt >= last_cnt);

    // Next rotation state in the selected direction, modulo four.
    always_comb phase_nxt = dir_up ? (phase_q + PHASE_W'(1))
                                   : (phase_q - PHASE_W'(1));

    // Prescaler and rotation state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= ZERO;
            phase_q <= '0;
        end else if (step_now) begin
            pre_cnt <= ZERO;
            phase_q <= phase_nxt;
        end else begin
            pre_cnt <= pre_cnt + ONE;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/qrot_rot_stage.sv
// qrot_rot_stage: one registered rotation stage. When ctrl_i is 1 the
// incoming point is turned by the fixed amount picked by KIND, otherwise it
// passes unchanged. A valid bit travels alongside with the same latency.
// Assumes ctrl_i is already aligned with pt_i.
module qrot_rot_stage import qrot_pkg::*; #(
    parameter rot_kind_e KIND = ROT_HALF
) (
    input  logic clk,
    input  logic rst_n,
    input  qpt_t pt_i,
    input  logic vld_i,
    input  logic ctrl_i,
    output qpt_t pt_o,
    output logic vld_o
);

    qpt_t turned;

    // Select the fixed turn this instance applies.
    generate
        if (KIND == ROT_HALF) begin : g_half
            always_comb turned = rot_half(pt_i);
        end else begin : g_quarter
            always_comb turned = rot_quarter(pt_i);
        end
    endgenerate

    // Register the rotated or passed point and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_o  <= '0;
            vld_o <= 1'b0;
        end else begin
            pt_o  <= ctrl_i ? turned : pt_i;
            vld_o <= vld_i;
        end
    end

endmodule

// File: rtl/qrot_mixer.sv
// qrot_mixer: quadrature state rotation mixer (top).
// Turns the 1-bit-per-axis input by the current rotation state through a
// half-turn stage followed by a quarter-turn stage, one register each.
// The quarter-turn control is delayed one cycle so both stages act on the
// same sample. Latency is two clocks. Assumes inputs are synchronous to clk.
module qrot_mixer import qrot_pkg::*; #(
    parameter int unsigned RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_up,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                in_i,
    input  logic                in_q,
    output logic                out_i,
    output logic                out_q,
    output logic                out_vld
);

    logic [PHASE_W-1:0] phase;
    logic               qtr_ctl_d;
    qpt_t               pt_in;
    qpt_t               pt_mid;
    logic               vld_mid;
    qpt_t               pt_out;

    // Pack the input sign bits into a point.
    always_comb begin
        pt_in.i = in_i;
        pt_in.q = in_q;
    end

    qrot_rate_gen #(.RELOAD_W(RELOAD_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_up  (dir_up),
        .reload  (reload),
        .phase_o (phase)
    );

    qrot_rot_stage #(.KIND(ROT_HALF)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .pt_i   (pt_in),
        .vld_i  (1'b1),
        .ctrl_i (phase[1]),
        .pt_o   (pt_mid),
        .vld_o  (vld_mid)
    );

    // Delay the quarter-turn control by the half-turn stage latency.
    always_ff @(posedge clk) begin
        if (!rst_n) qtr_ctl_d <= 1'b0;
        else        qtr_ctl_d <= phase[0];
    end

    qrot_rot_stage #(.KIND(ROT_QUARTER)) u_quarter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pt_i   (pt_mid),
        .vld_i  (vld_mid),
        .ctrl_i (qtr_ctl_d),
        .pt_o   (pt_out),
        .vld_o  (out_vld)
    );

    assign out_i = pt_out.i;
    assign out_q = pt_out.q;

endmodule

// File: rtl/qrot_mixer_chk.sv
// qrot_mixer_chk: temporal checks on the rotation mixer, bound to its top.
// Watches the ports and the rotation state; assumes a synchronous
// active-low reset held for at least two edges.
module qrot_mixer_chk #(
    parameter int unsigned RELOAD_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dir_up,
    input logic [RELOAD_W-1:0] reload,
    input logic                in_i,
    input logic                in_q,
    input logic                out_i,
    input logic                out_q,
    input logic                out_vld,
    input logic [1:0]          phase
);

    // R1
    pass_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(phase, 2) == 2'd0)
            |-> (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

    // R2
    half_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(phase, 2) == 2'd2)
            |-> (out_i == !$past(in_i, 2) && out_q == !$past(in_q, 2)));

    // R3
    quarter_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(phase, 2) == 2'd1)
            |-> (out_i == !$past(in_q, 2) && out_q == $past(in_i, 2)));

    // R3
    three_quarter_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(phase, 2) == 2'd3)
            |-> (out_i == $past(in_q, 2) && out_q == !$past(in_i, 2)));

    // R4
    step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase))
            |-> (phase == $past(phase) + ($past(dir_up) ? 2'd1 : 2'd3)));

    // R5
    fast_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reload) <= RELOAD_W'(1))
            |-> (phase != $past(phase)));

    // R8
    vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($past(rst_n) && $past(rst_n, 2)));

endmodule

bind qrot_mixer qrot_mixer_chk #(.RELOAD_W(RELOAD_W)) u_qrot_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_up  (dir_up),
    .reload  (reload),
    .in_i    (in_i),
    .in_q    (in_q),
    .out_i   (out_i),
    .out_q   (out_q),
    .out_vld (out_vld),
    .phase   (phase)
);

// File: tb/test_qrot_mixer.sv
// test_qrot_mixer: directed bench for the quadrature rotation mixer.
// A reference model built from the requirements predicts every output.
module test_qrot_mixer;

    localparam int unsigned RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir_up = 1'b1;
    logic [RW-1:0] reload = RW'(1);
    logic          in_i = 1'b0;
    logic          in_q = 1'b0;
    logic          out_i;
    logic          out_q;
    logic          out_vld;

    int n_run = 0;
    int n_fail = 0;

    // Reference model state.
    int         m_pre = 0;
    int         m_ph = 0;
    logic [1:0] p0 = 2'b00;
    logic [1:0] p1 = 2'b00;
    bit         v0 = 1'b0;
    bit         v1 = 1'b0;
    logic [1:0] last_out = 2'b00;

    always #10 clk = ~clk;

    qrot_mixer #(.RELOAD_W(RW)) i_qrot_mixer (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_up  (dir_up),
        .reload  (reload),
        .in_i    (in_i),
        .in_q    (in_q),
        .out_i   (out_i),
        .out_q   (out_q),
        .out_vld (out_vld)
    );

    // Expected point {i,q} turned counterclockwise by k quarter turns.
    function automatic logic [1:0] rotf(input logic [1:0] p, input int k);
        case (k)
            0:       return p;
            1:       return {~p[0], p[1]};
            2:       return ~p;
            default: return {p[0], ~p[1]};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one sample, advance the model one edge, check the output.
    task automatic step(input logic [1:0] pt, input string tag);
        int lastc;
        in_i = pt[1];
        in_q = pt[0];
        p1 = p0; v1 = v0;
        p0 = rotf(pt, m_ph); v0 = 1'b1;
        lastc = (reload == 0) ? 0 : int'(reload) - 1;
        if (m_pre >= lastc) begin
            m_pre = 0;
            m_ph = dir_up ? (m_ph + 1) % 4 : (m_ph + 3) % 4;
        end else begin
            m_pre++;
        end
        @(negedge clk);
        last_out = {out_i, out_q};
        chk(out_vld == v1, {tag, " valid"}, int'(out_vld), int'(v1));
        if (v1) chk(last_out == p1, {tag, " point"}, int'(last_out), int'(p1));
    endtask

    // R8: hold reset, check the reset state, release and clear the model.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R8 valid low in reset", int'(out_vld), 0);
        chk({out_i, out_q} == 2'b00, "R8 point zero in reset", int'({out_i, out_q}), 0);
        rst_n = 1'b1;
        m_pre = 0; m_ph = 0;
        p0 = 2'b00; p1 = 2'b00; v0 = 1'b0; v1 = 1'b0;
    endtask

    // R1 R2 R3: fixed input, one step per clock, count up.
    task automatic t_static_up();
        logic [1:0] seen [4];
        dir_up = 1'b1; reload = RW'(1);
        do_reset();
        step(2'b11, "R8 first edge");
        for (int k = 0; k < 4; k++) begin
            step(2'b11, "R1 static up");
            seen[k] = last_out;
        end
        chk(seen[0] == 2'b11, "R1 pass through", int'(seen[0]), 3);
        chk(seen[1] == 2'b01, "R3 quarter turn", int'(seen[1]), 1);
        chk(seen[2] == 2'b00, "R2 half turn", int'(seen[2]), 0);
        chk(seen[3] == 2'b10, "R3 three-quarter turn", int'(seen[3]), 2);
    endtask

    // R4: same input, counting down.
    task automatic t_static_down();
        logic [1:0] seen [4];
        dir_up = 1'b0; reload = RW'(1);
        do_reset();
        step(2'b11, "R4 first edge");
        for (int k = 0; k < 4; k++) begin
            step(2'b11, "R4 static down");
            seen[k] = last_out;
        end
        chk(seen[1] == 2'b10, "R4 down first step", int'(seen[1]), 2);
        chk(seen[3] == 2'b01, "R4 down third step", int'(seen[3]), 1);
    endtask

    // R5: slow rate, count output changes over twelve transitions.
    task automatic t_slow(input logic [RW-1:0] n, input int exp_changes, input string tag);
        int changes;
        logic [1:0] prev;
        dir_up = 1'b1; reload = n;
        do_reset();
        step(2'b10, tag);
        step(2'b10, tag);
        prev = last_out;
        changes = 0;
        for (int k = 0; k < 12; k++) begin
            step(2'b10, tag);
            if (last_out != prev) changes++;
            prev = last_out;
        end
        chk(changes == exp_changes, {tag, " change count"}, changes, exp_changes);
    endtask

    // R6 R7: input rotating counterclockwise cancelled by a down count.
    task automatic t_cancel();
        logic [1:0] seq [4];
        logic [1:0] first;
        bit         held;
        seq[0] = 2'b11; seq[1] = 2'b01; seq[2] = 2'b00; seq[3] = 2'b10;
        dir_up = 1'b0; reload = RW'(1);
        do_reset();
        step(seq[0], "R6 first edge");
        step(seq[1], "R6 align");
        first = last_out;
        held = 1'b1;
        for (int k = 2; k < 14; k++) begin
            step(seq[k % 4], "R6 align");
            if (last_out != first) held = 1'b0;
        end
        chk(held, "R7 output holds", int'(held), 1);
    endtask

    // R4 R5: change direction and rate mid-run without reset.
    task automatic t_mixed();
        dir_up = 1'b1; reload = RW'(2);
        do_reset();
        for (int k = 0; k < 10; k++) step(2'(k), "R4 mixed up");
        dir_up = 1'b0; reload = RW'(5);
        for (int k = 0; k < 12; k++) step(2'(k + 1), "R5 mixed down");
        reload = RW'(1);
        for (int k = 0; k < 6; k++) step(2'(3 * k), "R5 shrink reload");
    endtask

    // Watchdog: a hung run counts as a failure and still prints a summary.
    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_static_up();
        t_static_down();
        t_slow(RW'(3), 4, "R5 reload three");
        t_slow(RW'(0), 12, "R5 reload zero");
        t_cancel();
        t_mixed();
        t_static_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule